// File: doc/BRIEF.md
# Filtered TLB Invalidation Sequencer

This block walks a translation tag array and drops the "entry present" flag of every entry that a maintenance command selects. The array has two parts. The first part is set-associative: 8 ways of 256 lines, and all of its entries share one page size that comes from an input. The second part is fully associative, holds `ASSOC_N` entries, and each entry stores its own page size. Entry indices run from 0 to 2047 for the set-associative part, way-major, so entry = way*256 + line. The associative part follows at index 2048 and up.

A command carries an operation code, a 10-bit address-space tag, a global selector, a virtual address and an entry index. The sequencer latches the command and then steps through the entries it has to consider, one per clock. It reads each entry's global flag, address-space tag, stored page-pair number and page size through a combinational read port. On the same clock it asserts a clear strobe for that index when the entry qualifies. `busy` is high for exactly one cycle per visited entry. `done` then pulses for one cycle, and commands that arrive while busy are dropped.

The page test compares `vaddr >> (ps+1)` with `vppn >> (ps+1-13)`. Here `vppn` is the stored page-pair number, which holds address bits 47 down to 13, and `ps` is the page size that applies to that entry.

Top module: `tlbinv_engine`

## Requirements
- R1: After reset, `busy`, `done` and `tag_clr` are all low.
- R2: Operation 0 clears every entry of both sections.
- R3: Operation 1 clears the entries whose global flag equals `cmd_glob`.
- R4: Operation 2 clears the entries that are not global and whose tag equals `cmd_asid`.
- R5: Operation 3 clears the non-global entries that have a tag equal to `cmd_asid` and that pass the page test. The page test uses `ps` = `shared_ps` for indices below 2048 and the entry's own `ps` field for all other indices.
- R6: Operation 4 clears the entries that pass the page test and are either global or carry a tag equal to `cmd_asid`.
- R7: Operations 5 (clear line) and 6 (flush line) with `cmd_index` < 2048 visit only the entries way*256 + (cmd_index mod 256), for ways 0 to 7.
- R8: Operations 5 and 6 with 2048 <= `cmd_index` < 2048+ASSOC_N visit every associative entry. With a larger index they visit nothing, and `done` pulses on the cycle after acceptance with `busy` staying low.
- R9: Operation 6 clears every visited entry. Operation 5 clears only the visited entries that are not global and whose tag equals `cmd_asid`.
- R10: `busy` is high for exactly one cycle per visited entry. After the last one it falls, `done` is high for one cycle, and `busy` and `done` are never high together.
- R11: A command presented while `busy` is high is ignored, and the running operation finishes with its own fields.
- R12: Operation 7 modifies no entry, and `done` pulses on the cycle after acceptance without `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, accepted when not busy |
| cmd_op | input | 3 | Operation code 0..7 |
| cmd_asid | input | 10 | Address-space tag for filtering |
| cmd_glob | input | 1 | Global value selected by operation 1 |
| cmd_vaddr | input | 48 | Virtual address for page operations |
| cmd_index | input | 12 | Entry index for operations 5 and 6 |
| shared_ps | input | 6 | Page size of the set-associative section |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| tag_idx | output | 12 | Entry index being visited |
| tag_rd_glob | input | 1 | Global flag of the entry at `tag_idx` |
| tag_rd_asid | input | 10 | Tag of the entry at `tag_idx` |
| tag_rd_vppn | input | 35 | Stored page-pair number of the entry at `tag_idx` |
| tag_rd_ps | input | 6 | Own page size of the entry at `tag_idx` |
| tag_clr | output | 1 | Clear the present flag of `tag_idx` at this clock edge |

## Verification
The hardest case to reach is a page match that depends on which page size applies. The same stored page-pair number has to match under one page size and miss under another. The bench therefore fills the array so that the number stored in every fourth entry differs from the target only in its lowest bit. That bit is compared when the shared page size is 12, but it drops out of the comparison in associative entries with page sizes 14 and 21. A second hard case is a command arriving while a walk is in progress. The bench injects an operation 0 partway through a tag-filtered walk, and the final array must match the result of the tag-filtered walk alone.

// File: rtl/tlbinv_pkg.sv
package tlbinv_pkg;
  typedef enum logic [2:0] {
    OP_ALL       = 3'd0,
    OP_GLB       = 3'd1,
    OP_ASID      = 3'd2,
    OP_PG_ASID   = 3'd3,
    OP_PG_ASID_G = 3'd4,
    OP_CLR_LINE  = 3'd5,
    OP_FLS_LINE  = 3'd6,
    OP_NOP       = 3'd7
  } inv_op_e;
endpackage

// File: rtl/tlbinv_filter.sv
module tlbinv_filter
  import tlbinv_pkg::*;
#(
  parameter int ASID_W  = 10,
  parameter int VA_W    = 48,
  parameter int PS_W    = 6,
  parameter int VPN_LSB = 13,
  localparam int VPPN_W = VA_W - VPN_LSB
) (
  input  inv_op_e           op,
  input  logic [ASID_W-1:0] cmd_asid,
  input  logic              cmd_glob,
  input  logic [VA_W-1:0]   cmd_vaddr,
  input  logic              ent_glob,
  input  logic [ASID_W-1:0] ent_asid,
  input  logic [VPPN_W-1:0] ent_vppn,
  input  logic [PS_W-1:0]   eff_ps,
  output logic              hit
);
  logic            asid_eq;
  logic            page_eq;
  logic [PS_W:0]   shamt;
  logic [VA_W-1:0] ent_va;
  logic [VA_W-1:0] diff;

  always_comb begin
    asid_eq = (ent_asid == cmd_asid);
    ent_va  = {ent_vppn, {VPN_LSB{1'b0}}};
    shamt   = {1'b0, eff_ps} + {{PS_W{1'b0}}, 1'b1};
    diff    = (cmd_vaddr ^ ent_va) >> shamt;
    page_eq = (diff == '0);
    unique case (op)
      OP_ALL:       hit = 1'b1;
      OP_GLB:       hit = (ent_glob == cmd_glob);
      OP_ASID:      hit = !ent_glob && asid_eq;
      OP_PG_ASID:   hit = !ent_glob && asid_eq && page_eq;
      OP_PG_ASID_G: hit = (ent_glob || asid_eq) && page_eq;
      OP_CLR_LINE:  hit = !ent_glob && asid_eq;
      OP_FLS_LINE:  hit = 1'b1;
      default:      hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/tlbinv_walker.sv
module tlbinv_walker
  import tlbinv_pkg::*;
#(
  parameter int WAYS    = 8,
  parameter int LINES   = 256,
  parameter int ASSOC_N = 64,
  localparam int SA_N   = WAYS * LINES,
  localparam int TOTAL  = SA_N + ASSOC_N,
  localparam int IDX_W  = $clog2(TOTAL),
  localparam int LINE_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc,
  input  inv_op_e          op,
  input  logic [IDX_W-1:0] index,
  output logic             busy,
  output logic             done,
  output logic [IDX_W-1:0] idx
);
  logic             busy_q, busy_d;
  logic             done_q, done_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [IDX_W-1:0] last_q, last_d;
  logic             big_q, big_d;
  logic             idx_en;

  // range decode for a new command
  logic [IDX_W-1:0] r_first, r_last;
  logic             r_big, r_empty;
  logic [IDX_W-1:0] line_idx;

  always_comb begin
    line_idx = {{(IDX_W-LINE_W){1'b0}}, index[LINE_W-1:0]};
    r_first  = '0;
    r_last   = IDX_W'(TOTAL - 1);
    r_big    = 1'b0;
    r_empty  = 1'b0;
    if (op == OP_CLR_LINE || op == OP_FLS_LINE) begin
      if (index < IDX_W'(SA_N)) begin
        r_first = line_idx;
        r_last  = IDX_W'((WAYS - 1) * LINES) + line_idx;
        r_big   = 1'b1;
      end else if (index < IDX_W'(TOTAL)) begin
        r_first = IDX_W'(SA_N);
      end else begin
        r_empty = 1'b1;
      end
    end else if (op == OP_NOP) begin
      r_empty = 1'b1;
    end
  end

  // next state
  always_comb begin
    busy_d = busy_q;
    done_d = 1'b0;
    idx_d  = idx_q;
    last_d = last_q;
    big_d  = big_q;
    idx_en = 1'b0;
    if (busy_q) begin
      idx_en = 1'b1;
      if (idx_q == last_q) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end else begin
        idx_d = idx_q + (big_q ? IDX_W'(LINES) : IDX_W'(1));
      end
    end else if (acc) begin
      idx_en = 1'b1;
      if (r_empty) begin
        done_d = 1'b1;
      end else begin
        busy_d = 1'b1;
        idx_d  = r_first;
        last_d = r_last;
        big_d  = r_big;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      last_q <= '0;
      big_q  <= 1'b0;
    end else if (idx_en) begin
      idx_q  <= idx_d;
      last_q <= last_d;
      big_q  <= big_d;
    end
  end

  assign busy = busy_q;
  assign done = done_q;
  assign idx  = idx_q;

  // R10
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_q && done_q));
  // R10
  walk_continue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && (idx_q != last_q) |=> busy_q);
  // R10
  walk_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && (idx_q == last_q) |=> !busy_q && done_q);
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q && !acc |=> !done_q);
  // R7
  line_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && big_q && (idx_q != last_q) |=> idx_q[LINE_W-1:0] == $past(idx_q[LINE_W-1:0]));
endmodule

// File: rtl/tlbinv_engine.sv
module tlbinv_engine
  import tlbinv_pkg::*;
#(
  parameter int ASSOC_N = 64,
  parameter int WAYS    = 8,
  parameter int LINES   = 256,
  parameter int ASID_W  = 10,
  parameter int VA_W    = 48,
  parameter int PS_W    = 6,
  parameter int VPN_LSB = 13,
  localparam int SA_N   = WAYS * LINES,
  localparam int TOTAL  = SA_N + ASSOC_N,
  localparam int IDX_W  = $clog2(TOTAL),
  localparam int VPPN_W = VA_W - VPN_LSB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [ASID_W-1:0] cmd_asid,
  input  logic              cmd_glob,
  input  logic [VA_W-1:0]   cmd_vaddr,
  input  logic [IDX_W-1:0]  cmd_index,
  input  logic [PS_W-1:0]   shared_ps,
  output logic              busy,
  output logic              done,
  output logic [IDX_W-1:0]  tag_idx,
  input  logic              tag_rd_glob,
  input  logic [ASID_W-1:0] tag_rd_asid,
  input  logic [VPPN_W-1:0] tag_rd_vppn,
  input  logic [PS_W-1:0]   tag_rd_ps,
  output logic              tag_clr
);
  logic              acc;
  logic              busy_w;
  logic              hit;
  logic [IDX_W-1:0]  idx_w;
  logic [PS_W-1:0]   eff_ps;

  inv_op_e           op_q;
  logic [ASID_W-1:0] asid_q;
  logic              glob_q;
  logic [VA_W-1:0]   va_q;
  logic [PS_W-1:0]   ps_q;

  assign acc = cmd_valid && !busy_w;

  // command hold register, loaded only on acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= OP_NOP;
      asid_q <= '0;
      glob_q <= 1'b0;
      va_q   <= '0;
      ps_q   <= '0;
    end else if (acc) begin
      op_q   <= inv_op_e'(cmd_op);
      asid_q <= cmd_asid;
      glob_q <= cmd_glob;
      va_q   <= cmd_vaddr;
      ps_q   <= shared_ps;
    end
  end

  tlbinv_walker #(
    .WAYS    (WAYS),
    .LINES   (LINES),
    .ASSOC_N (ASSOC_N)
  ) u_walker (
    .clk   (clk),
    .rst_n (rst_n),
    .acc   (acc),
    .op    (inv_op_e'(cmd_op)),
    .index (cmd_index),
    .busy  (busy_w),
    .done  (done),
    .idx   (idx_w)
  );

  always_comb begin
    eff_ps = (idx_w < IDX_W'(SA_N)) ? ps_q : tag_rd_ps;
  end

  tlbinv_filter #(
    .ASID_W  (ASID_W),
    .VA_W    (VA_W),
    .PS_W    (PS_W),
    .VPN_LSB (VPN_LSB)
  ) u_filter (
    .op        (op_q),
    .cmd_asid  (asid_q),
    .cmd_glob  (glob_q),
    .cmd_vaddr (va_q),
    .ent_glob  (tag_rd_glob),
    .ent_asid  (tag_rd_asid),
    .ent_vppn  (tag_rd_vppn),
    .eff_ps    (eff_ps),
    .hit       (hit)
  );

  assign busy    = busy_w;
  assign tag_idx = idx_w;
  assign tag_clr = busy_w && hit;

  // R12
  clr_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tag_clr |-> busy_w);
  // R11
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_w |=> $stable(op_q) && $stable(asid_q) && $stable(va_q) && $stable(ps_q));
  // R9
  clear_spares_global_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_w && (op_q == OP_CLR_LINE) && tag_rd_glob |-> !tag_clr);
  // R4
  asid_spares_global_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_w && (op_q == OP_ASID) && tag_rd_glob |-> !tag_clr);
  // R1
  reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !busy_w && !done);
endmodule

// File: tb/tlbinv_engine_tb.sv
module tlbinv_engine_tb;
  localparam int SA    = 2048;
  localparam int AN    = 64;
  localparam int TOT   = SA + AN;
  localparam logic [47:0] VA_T = 48'h1234_5678_9000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_op = 3'd7;
  logic [9:0]  cmd_asid = '0;
  logic        cmd_glob = 1'b0;
  logic [47:0] cmd_vaddr = '0;
  logic [11:0] cmd_index = '0;
  logic [5:0]  shared_ps = 6'd12;
  logic        busy, done, tag_clr;
  logic [11:0] tag_idx;
  logic        tag_rd_glob;
  logic [9:0]  tag_rd_asid;
  logic [34:0] tag_rd_vppn;
  logic [5:0]  tag_rd_ps;

  logic        m_ex   [TOT];
  logic        m_gl   [TOT];
  logic [9:0]  m_asid [TOT];
  logic [34:0] m_vppn [TOT];
  logic [5:0]  m_ps   [TOT];
  logic        e_ex   [TOT];

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  tlbinv_engine u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_asid(cmd_asid), .cmd_glob(cmd_glob), .cmd_vaddr(cmd_vaddr),
    .cmd_index(cmd_index), .shared_ps(shared_ps), .busy(busy), .done(done),
    .tag_idx(tag_idx), .tag_rd_glob(tag_rd_glob), .tag_rd_asid(tag_rd_asid),
    .tag_rd_vppn(tag_rd_vppn), .tag_rd_ps(tag_rd_ps), .tag_clr(tag_clr)
  );

  assign tag_rd_glob = (int'(tag_idx) < TOT) ? m_gl[tag_idx]   : 1'b0;
  assign tag_rd_asid = (int'(tag_idx) < TOT) ? m_asid[tag_idx] : '0;
  assign tag_rd_vppn = (int'(tag_idx) < TOT) ? m_vppn[tag_idx] : '0;
  assign tag_rd_ps   = (int'(tag_idx) < TOT) ? m_ps[tag_idx]   : '0;

  always @(posedge clk) if (tag_clr && int'(tag_idx) < TOT) m_ex[tag_idx] <= 1'b0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual cycles %0d expected < 150000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors);
      $finish;
    end
  end

  task automatic check(input string tag, input longint act, input longint exp);
    checks = checks + 1;
    if (act != exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic fill(input int seed);
    for (int i = 0; i < TOT; i++) begin
      m_ex[i]   = 1'b1;
      m_gl[i]   = (((i * 7 + seed) % 5) == 0);
      m_asid[i] = ((i + seed) % 3 == 0) ? 10'h155 : (((i + seed) % 3 == 1) ? 10'h02a : 10'h3ff);
      m_ps[i]   = (i < SA) ? 6'd0 : ((i % 2 == 1) ? 6'd21 : 6'd14);
      case (i % 4)
        0: m_vppn[i] = 35'(VA_T >> 13);
        1: m_vppn[i] = 35'(VA_T >> 13) ^ 35'd1;
        2: m_vppn[i] = 35'(VA_T >> 13) ^ (35'd1 << 12);
        default: m_vppn[i] = 35'(i * 12345 + seed);
      endcase
    end
  endtask

  function automatic bit page_ok(int i, logic [47:0] va);
    int p;
    longint unsigned a, v;
    p = (i < SA) ? int'(shared_ps) : int'(m_ps[i]);
    a = longint'(va) >> (p + 1);
    v = longint'(m_vppn[i]) >> (p + 1 - 13);
    return a == v;
  endfunction

  function automatic bit visits(int i, int op, int idx);
    if (op <= 4) return 1'b1;
    if (op == 7) return 1'b0;
    if (idx < SA) return (i < SA) && ((i % 256) == (idx % 256));
    if (idx < TOT) return i >= SA;
    return 1'b0;
  endfunction

  function automatic bit wants(int i, int op, logic [9:0] as, logic g, logic [47:0] va, int idx);
    bit eq;
    eq = (m_asid[i] == as);
    if (!visits(i, op, idx)) return 1'b0;
    case (op)
      0: return 1'b1;
      1: return m_gl[i] == g;
      2: return !m_gl[i] && eq;
      3: return !m_gl[i] && eq && page_ok(i, va);
      4: return (m_gl[i] || eq) && page_ok(i, va);
      5: return !m_gl[i] && eq;
      6: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic run_op(input string tag, input int op, input logic [9:0] as, input logic g,
                        input logic [47:0] va, input int idx, input bit inject);
    int exp_n, n, bad, first_bad;
    exp_n = 0;
    for (int i = 0; i < TOT; i++) begin
      e_ex[i] = m_ex[i] & ~wants(i, op, as, g, va, idx);
      if (visits(i, op, idx)) exp_n++;
    end
    @(negedge clk);
    cmd_op = 3'(op); cmd_asid = as; cmd_glob = g; cmd_vaddr = va;
    cmd_index = 12'(idx); cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    n = 0;
    while (busy && n < 5000) begin
      n++;
      if (inject && n == 50) begin cmd_op = 3'd0; cmd_valid = 1'b1; end
      if (inject && n == 51) cmd_valid = 1'b0;
      if (done) check({tag, " R10 done during busy"}, 1, 0);
      @(negedge clk);
    end
    cmd_valid = 1'b0;
    check({tag, " R10 visited cycles"}, n, exp_n);
    check({tag, " R10 done pulse high"}, done, 1);
    bad = 0; first_bad = -1;
    for (int i = 0; i < TOT; i++)
      if (m_ex[i] !== e_ex[i]) begin bad++; if (first_bad < 0) first_bad = i; end
    if (bad != 0) $display("  %s first mismatch at entry %0d: actual %0b expected %0b",
                           tag, first_bad, m_ex[first_bad], e_ex[first_bad]);
    check({tag, " entry mismatches"}, bad, 0);
    @(negedge clk);
    check({tag, " R10 done pulse low"}, done, 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 busy", busy, 0);
    check("R1 done", done, 0);
    check("R1 tag_clr", tag_clr, 0);
  endtask

  task automatic t_all();        fill(1); run_op("R2 all", 0, 10'h0, 1'b0, 48'h0, 0, 0); endtask
  task automatic t_glob();
    fill(2); run_op("R3 glob=1", 1, 10'h0, 1'b1, 48'h0, 0, 0);
    fill(3); run_op("R3 glob=0", 1, 10'h0, 1'b0, 48'h0, 0, 0);
  endtask
  task automatic t_asid();       fill(4); run_op("R4 asid", 2, 10'h155, 1'b0, 48'h0, 0, 0); endtask
  task automatic t_page_asid();
    fill(5); run_op("R5 page asid", 3, 10'h02a, 1'b0, VA_T, 0, 0);
    fill(6); run_op("R5 page asid va+8k", 3, 10'h3ff, 1'b0, VA_T + 48'h2000, 0, 0);
  endtask
  task automatic t_page_or_g();  fill(7); run_op("R6 page asid or g", 4, 10'h155, 1'b0, VA_T, 0, 0); endtask
  task automatic t_lines();
    fill(8);  run_op("R7 R9 clear line 37", 5, 10'h155, 1'b0, 48'h0, 37, 0);
    fill(9);  run_op("R7 R9 flush line 300", 6, 10'h0, 1'b0, 48'h0, 300, 0);
    fill(10); run_op("R8 R9 clear assoc", 5, 10'h02a, 1'b0, 48'h0, 2050, 0);
    fill(11); run_op("R8 R9 flush assoc", 6, 10'h0, 1'b0, 48'h0, 2111, 0);
    fill(12); run_op("R8 out of range", 6, 10'h0, 1'b0, 48'h0, 3000, 0);
  endtask
  task automatic t_busy_ignore(); fill(13); run_op("R11 ignored while busy", 2, 10'h3ff, 1'b0, 48'h0, 0, 1); endtask
  task automatic t_nop();        fill(14); run_op("R12 reserved op", 7, 10'h155, 1'b1, VA_T, 0, 0); endtask

  initial begin
    fill(0);
    repeat (3) @(negedge clk);
    check("R1 busy in reset", busy, 0);
    rst_n = 1'b1;
    t_reset();
    t_all();
    t_glob();
    t_asid();
    t_page_asid();
    t_page_or_g();
    t_lines();
    t_busy_ignore();
    t_nop();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule